// File: doc/BRIEF.md
# Dual-Port Video Row Shifter

This block models a video memory with two independent ports. A random-access port reads and writes single words of a small array organised as rows of columns. A serial port streams one row at a time to a display path. The controller picks the line to show by issuing a transfer for one row. In one clock the block copies every word of that row into an internal row buffer that acts as a shift register.

After the transfer, each shift pulse moves the serial output to the next word of the buffered row, in increasing column order. One row is one display line. The random-access port keeps reading and writing the array while the line is streamed. Because the buffer is a snapshot, those writes do not disturb the line in flight.

When a shift pulse consumes the last column, the serial output keeps showing that word and a line-done flag goes high. The flag stays high until the next transfer. The shift pulse is a synchronous enable on the system clock.

Top module: `vrs_top`

## Requirements
- R1: After reset, ra_rdata_o is 0, ser_data_o is 0, line_done_o is 1, and every array word reads back as 0. Shift pulses before the first transfer change nothing.
- R2: The array word index is {row, column}, with the row in the upper ROW_W bits of ra_addr_i. In each cycle without a transfer, ra_rdata_o shows, one clock later, the word at ra_addr_i as it stood before that edge. When ra_we_i is also high, ra_wdata_i is stored at ra_addr_i, and a later read returns the new word.
- R3: A cycle with xfer_req_i high loads the whole row xfer_row_i into the row buffer. From the next cycle ser_data_o shows column 0 of that row and line_done_o is 0.
- R4: Each cycle with shift_en_i high, no transfer, and line_done_o low moves ser_data_o one clock later to the next higher column of the buffered row. Without a shift pulse or a transfer, ser_data_o and line_done_o hold.
- R5: A shift pulse while the last column is shown raises line_done_o one clock later, and ser_data_o keeps the last column's word. Further shift pulses change neither output until the next transfer.
- R6: Writes to the array after a transfer do not change the words that the serial port delivers for that line.
- R7: A transfer takes priority over the random-access port in the same cycle. A write in that cycle is dropped, leaving the array unchanged, and ra_rdata_o holds its previous value.
- R8: A transfer takes priority over a shift pulse in the same cycle. A transfer in the middle of a line restarts the serial output at column 0 of the new row.
- R9: Reads and writes on the random-access port give the R2 results while the serial port is shifting, and the shifting is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_addr_i | input | ROW_W+COL_W | Random-access word address {row, column} |
| ra_wdata_i | input | WORD_W | Random-access write data |
| ra_we_i | input | 1 | Random-access write enable |
| ra_rdata_o | output | WORD_W | Registered random-access read data |
| xfer_req_i | input | 1 | Row transfer request |
| xfer_row_i | input | ROW_W | Row to copy into the row buffer |
| shift_en_i | input | 1 | Shift pulse, synchronous enable |
| ser_data_o | output | WORD_W | Serial video output word |
| line_done_o | output | 1 | Last word of the line has been consumed |

## Verification
The bench streams whole lines and checks that the output stops on the last column and raises the flag one pulse after that column appears. A design that wrapped to column 0, or raised the flag a pulse early, would deliver a wrong or short line. It rewrites a row while that row is being shifted out, which catches a buffer that reads the array live instead of holding a snapshot. It also collides a transfer with a write, and then with a shift, to catch an arbitration that lets the write land, moves the read data, or starts the new line at column 1. Finally it checks reads that coincide with writes, where the old word must come back. A design that passed the new data straight through would fail there.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [1:0] {
    RA_READ    = 2'd0,
    RA_WRITE   = 2'd1,
    RA_BLOCKED = 2'd2
  } ra_op_e;
endpackage

// File: rtl/vrs_array.sv
module vrs_array #(
  parameter int WORD_W = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  vrs_pkg::ra_op_e                   op_i,
  input  logic [ROW_W+COL_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]                 wdata_i,
  output logic [WORD_W-1:0]                 rdata_o,
  input  logic [ROW_W-1:0]                  row_sel_i,
  output logic [(1<<COL_W)-1:0][WORD_W-1:0] row_o
);
  localparam int WORDS = 1 << COL_W;
  localparam int DEPTH = 1 << (ROW_W + COL_W);

  logic [DEPTH-1:0][WORD_W-1:0] mem_q;
  logic [WORD_W-1:0]            rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (op_i)
        vrs_pkg::RA_WRITE: begin
          rdata_q        <= mem_q[addr_i];
          mem_q[addr_i]  <= wdata_i;
        end
        vrs_pkg::RA_READ: rdata_q <= mem_q[addr_i];
        default: ;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // wide row read port for the transfer
  for (genvar c = 0; c < WORDS; c++) begin : g_row
    localparam logic [COL_W-1:0] CI = COL_W'(c);
    assign row_o[c] = mem_q[{row_sel_i, CI}];
  end
endmodule

// File: rtl/vrs_shift_row.sv
module vrs_shift_row #(
  parameter int WORD_W = 8,
  parameter int WORDS  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic                         adv_i,
  input  logic [WORDS-1:0][WORD_W-1:0] row_i,
  output logic [WORD_W-1:0]            ser_o
);
  logic [WORDS-1:0][WORD_W-1:0] stage_q, stage_d;

  for (genvar i = 0; i < WORDS; i++) begin : g_stage
    if (i == WORDS - 1) begin : g_tail
      assign stage_d[i] = load_i ? row_i[i] : stage_q[i];
    end else begin : g_body
      assign stage_d[i] = load_i ? row_i[i] :
                          adv_i  ? stage_q[i+1] : stage_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign ser_o = stage_q[0];
endmodule

// File: rtl/vrs_line_ctl.sv
module vrs_line_ctl #(
  parameter int COL_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_i,
  input  logic shift_i,
  output logic load_o,
  output logic adv_o,
  output logic done_o
);
  localparam logic [COL_W-1:0] LAST = {COL_W{1'b1}};

  logic [COL_W-1:0] pos_q;
  logic             done_q;
  logic             step;

  assign step = shift_i & ~done_q & ~xfer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      done_q <= 1'b1;
    end else if (xfer_i) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      if (pos_q == LAST) done_q <= 1'b1;
      else               pos_q  <= pos_q + 1'b1;
    end
  end

  assign load_o = xfer_i;
  assign adv_o  = step & (pos_q != LAST);
  assign done_o = done_q;
endmodule

// File: rtl/vrs_top.sv
module vrs_top #(
  parameter int WORD_W = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ROW_W+COL_W-1:0] ra_addr_i,
  input  logic [WORD_W-1:0]      ra_wdata_i,
  input  logic                   ra_we_i,
  output logic [WORD_W-1:0]      ra_rdata_o,
  input  logic                   xfer_req_i,
  input  logic [ROW_W-1:0]       xfer_row_i,
  input  logic                   shift_en_i,
  output logic [WORD_W-1:0]      ser_data_o,
  output logic                   line_done_o
);
  localparam int WORDS = 1 << COL_W;

  vrs_pkg::ra_op_e              ra_op;
  logic [WORDS-1:0][WORD_W-1:0] row_w;
  logic                         load_w, adv_w;

  // transfer wins over the random-access port
  always_comb begin
    if (xfer_req_i)   ra_op = vrs_pkg::RA_BLOCKED;
    else if (ra_we_i) ra_op = vrs_pkg::RA_WRITE;
    else              ra_op = vrs_pkg::RA_READ;
  end

  vrs_array #(.WORD_W(WORD_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (ra_op),
    .addr_i    (ra_addr_i),
    .wdata_i   (ra_wdata_i),
    .rdata_o   (ra_rdata_o),
    .row_sel_i (xfer_row_i),
    .row_o     (row_w)
  );

  vrs_line_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .xfer_i  (xfer_req_i),
    .shift_i (shift_en_i),
    .load_o  (load_w),
    .adv_o   (adv_w),
    .done_o  (line_done_o)
  );

  vrs_shift_row #(.WORD_W(WORD_W), .WORDS(WORDS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .adv_i  (adv_w),
    .row_i  (row_w),
    .ser_o  (ser_data_o)
  );
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
  parameter int WORD_W = 8,
  parameter int COL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_req_i,
  input logic              shift_en_i,
  input logic              line_done_o,
  input logic [WORD_W-1:0] ser_data_o,
  input logic [WORD_W-1:0] ra_rdata_o
);
  localparam int WORDS = 1 << COL_W;
  localparam logic [COL_W:0] FULL = (COL_W+1)'(WORDS);

  logic [COL_W:0] pulses_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         pulses_q <= FULL;
    else if (xfer_req_i)                 pulses_q <= '0;
    else if (shift_en_i && !line_done_o) pulses_q <= pulses_q + 1'b1;
  end

  AST_XFER_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_i |=> !line_done_o); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_req_i && !shift_en_i) |=> ($stable(ser_data_o) && $stable(line_done_o))); // R4
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_done_o && !xfer_req_i) |=> (line_done_o && $stable(ser_data_o))); // R5
  AST_DONE_AT_FULL_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_done_o) |-> (pulses_q == FULL)); // R5
  AST_NO_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_done_o |-> (pulses_q < FULL)); // R5
  AST_XFER_HOLDS_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_i |=> $stable(ra_rdata_o)); // R7
endmodule

bind vrs_top vrs_checker #(.WORD_W(WORD_W), .COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_req_i  (xfer_req_i),
  .shift_en_i  (shift_en_i),
  .line_done_o (line_done_o),
  .ser_data_o  (ser_data_o),
  .ra_rdata_o  (ra_rdata_o)
);

// File: tb/sim_vrs_top.sv
module sim_vrs_top;
  localparam int WORD_W = 8;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 3;
  localparam int WORDS  = 1 << COL_W;
  localparam int DEPTH  = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst_n;
  logic [ROW_W+COL_W-1:0] addr;
  logic [WORD_W-1:0]      wdata;
  logic                   we;
  logic [WORD_W-1:0]      rdata;
  logic                   xfer;
  logic [ROW_W-1:0]       xrow;
  logic                   shift;
  logic [WORD_W-1:0]      ser;
  logic                   done;

  vrs_top #(.WORD_W(WORD_W), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ra_addr_i(addr), .ra_wdata_i(wdata),
    .ra_we_i(we), .ra_rdata_o(rdata), .xfer_req_i(xfer), .xfer_row_i(xrow),
    .shift_en_i(shift), .ser_data_o(ser), .line_done_o(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [WORD_W-1:0] model [DEPTH];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int aof(input int r, input int c);
    return r * WORDS + c;
  endfunction

  function automatic logic [WORD_W-1:0] pat(input int a, input int s);
    return WORD_W'((a * 7 + s * 13) ^ 8'h5A);
  endfunction

  task automatic do_write(input int a, input logic [WORD_W-1:0] d);
    addr = (ROW_W+COL_W)'(a); wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
    model[a] = d;
  endtask

  task automatic do_read(input string req, input int a);
    addr = (ROW_W+COL_W)'(a);
    tick();
    chk(req, rdata, model[a]);
  endtask

  task automatic do_xfer(input int r);
    xfer = 1'b1; xrow = ROW_W'(r);
    tick();
    xfer = 1'b0;
  endtask

  task automatic do_shift();
    shift = 1'b1;
    tick();
    shift = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 0);
    chk("R1 ser", ser, 0);
    chk("R1 done", done, 1);
    do_shift();
    chk("R1 shift ignored ser", ser, 0);
    chk("R1 shift ignored done", done, 1);
    do_read("R1 array zero", 5);
    do_read("R1 array zero", DEPTH - 1);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) do_write(a, pat(a, 1));
    for (int a = 0; a < DEPTH; a++) do_read("R2 readback", a);
    begin
      logic [WORD_W-1:0] old;
      old = model[3];
      addr = 3; wdata = ~old; we = 1'b1;
      tick();
      we = 1'b0;
      chk("R2 read before write", rdata, old);
      model[3] = ~old;
      do_read("R2 new word", 3);
    end
  endtask

  task automatic t_line(input int r);
    logic [WORD_W-1:0] exp [WORDS];
    for (int c = 0; c < WORDS; c++) exp[c] = model[aof(r, c)];
    do_xfer(r);
    chk("R3 first word", ser, exp[0]);
    chk("R3 done low", done, 0);
    for (int c = 1; c < WORDS; c++) begin
      do_shift();
      chk("R4 next word", ser, exp[c]);
      chk("R4 done low", done, 0);
    end
    tick();
    chk("R4 hold without pulse", ser, exp[WORDS-1]);
    do_shift();
    chk("R5 done raised", done, 1);
    chk("R5 last word held", ser, exp[WORDS-1]);
    do_shift();
    chk("R5 extra pulse ignored", ser, exp[WORDS-1]);
    chk("R5 done stays", done, 1);
  endtask

  task automatic t_snapshot();
    logic [WORD_W-1:0] exp [WORDS];
    for (int c = 0; c < WORDS; c++) exp[c] = model[aof(1, c)];
    do_xfer(1);
    for (int c = 0; c < WORDS; c++) begin
      chk("R6 buffered word", ser, exp[c]);
      addr = (ROW_W+COL_W)'(aof(1, c)); wdata = pat(c, 9); we = 1'b1; shift = 1'b1;
      tick();
      we = 1'b0; shift = 1'b0;
      chk("R9 read during shift", rdata, exp[c]);
      model[aof(1, c)] = pat(c, 9);
    end
    chk("R6 last word after rewrite", ser, exp[WORDS-1]);
    chk("R9 done after line", done, 1);
    for (int c = 0; c < WORDS; c++) do_read("R9 write landed", aof(1, c));
  endtask

  task automatic t_prio();
    logic [WORD_W-1:0] held;
    do_read("R7 prior read", 9);
    held = model[9];
    xfer = 1'b1; xrow = 3; addr = 20; wdata = ~model[20]; we = 1'b1;
    tick();
    xfer = 1'b0; we = 1'b0;
    chk("R7 rdata held", rdata, held);
    chk("R3 row 3 col 0", ser, model[aof(3, 0)]);
    do_read("R7 write dropped", 20);
    do_shift();
    do_shift();
    chk("R4 row 3 col 2", ser, model[aof(3, 2)]);
    xfer = 1'b1; xrow = 0; shift = 1'b1;
    tick();
    xfer = 1'b0; shift = 1'b0;
    chk("R8 restart col 0", ser, model[aof(0, 0)]);
    chk("R8 done low", done, 0);
    do_shift();
    chk("R8 then col 1", ser, model[aof(0, 1)]);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0;
    xfer = 1'b0; xrow = '0; shift = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fill();
    t_line(2);
    t_line(0);
    t_snapshot();
    t_prio();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule